// File: doc/BRIEF.md
# Dual-Domain Reset and Power-Down Controller

This block produces the two internal resets of a small mixed-signal interface chip. The counter reset clears the sequencing counters and state. The register reset clears the programmable control registers. Four sources feed them: a power-on indication, an active-low external reset pin, an active-low hardware power-down pin, and a software reset bit. The hardware power-down pin drives only the counter reset, so the programmed settings survive a full-chip power-down. Both resets assert asynchronously. Each one is stretched by a small state machine, and its release is timed to a falling edge of the master clock.

The block also holds the two registers that the rest of the chip programs. The configuration register sits at address 0. The control register sits at address 1 and carries the software reset request and the software power-down request. The software power-down bit switches off only the analog section, so software can power the chip up again. The pin switches off the whole chip. The counter reset clears the software power-down bit. The software reset bit clears itself through the register reset it triggers.

Each domain's stretcher has three states. `ST_RUN` means the reset is released. `ST_HOLD` means a source is still active. `ST_DRAIN` means the post-release stretch is running. The transitions are:
- T_ASSERT (any state to `ST_HOLD`): an asynchronous source rises, or the software request is seen while in `ST_RUN`.
- T_DRAIN (`ST_HOLD` to `ST_DRAIN`): both the synchronised pin indication and the software request are clear.
- T_REARM (`ST_DRAIN` to `ST_HOLD`): a source returns during the stretch.
- T_DONE (`ST_DRAIN` to `ST_RUN`): the stretch counter reaches `STRETCH_CYC`-1.

Top module: `dual_reset_ctrl`

## Requirements
- R1: `cnt_rst_o` is high, without waiting for a clock edge, whenever `por_i` is high, `ext_rst_n` is low or `hw_pd_n` is low. It is also high during a software reset pulse.
- R2: `reg_rst_o` follows `por_i`, `ext_rst_n` and the software reset only. A low `hw_pd_n` on its own never raises it.
- R3: Pin and power-on resets release both outputs on the (`STRETCH_CYC`+3)-th falling edge of `mclk` after the last source goes inactive. A software reset raises both outputs on the first falling edge after the rising edge that wrote it, and releases them on the (`STRETCH_CYC`+2)-th falling edge after that write. Every pulse lasts at least one full clock period.
- R4: Whenever `cnt_rst_o` is high, the software power-down bit is cleared. `ext_rst_n` low or `hw_pd_n` low therefore also clears it.
- R5: A write to address 1 (`wr_addr`=1) on a rising edge of `mclk` loads bit 0 of `wr_data` into the software power-down bit and bit 1 into the software reset request. Writing bit 0 as zero clears the power-down bit.
- R6: `chip_pd_o` is the inverse of `hw_pd_n`. `ana_pd_o` is high when the software power-down bit is set or `chip_pd_o` is high.
- R7: The configuration register (`wr_addr`=0) holds `CFG_DEFAULT` (8'd18) after every register reset. A hardware power-down leaves its content unchanged. Outside register reset, it loads `wr_data` on a write.
- R8: One software reset write produces exactly one reset pulse. The request bit clears itself, and no further pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| por_i | input | 1 | Power-on reset indication, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| hw_pd_n | input | 1 | Hardware power-down pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe, sampled on rising edge |
| wr_addr | input | 1 | Register select: 0 configuration, 1 control |
| wr_data | input | DW | Register write data |
| cnt_rst_o | output | 1 | Counter-domain reset, active high |
| reg_rst_o | output | 1 | Register-domain reset, active high |
| ana_pd_o | output | 1 | Analog section power-down enable |
| chip_pd_o | output | 1 | Full-chip power-down enable |
| cfg_q_o | output | DW | Configuration register contents |

## Verification
Two functions can fall in the same cycle: a hardware power-down that holds the counter reset, and a software reset written while that pin is low. The bench writes the reset request during a long power-down. It then expects the register reset to run its own short software-length pulse. The counter reset must stay high until the pin returns and then release on the pin schedule. The configuration register must end at its default value. Random rounds also mix pin, power-down and software sources with random hold lengths and random prior register contents.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2
    } stretch_state_t;

    localparam logic ADDR_CFG  = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    localparam int unsigned CTRL_PD_BIT  = 0;
    localparam int unsigned CTRL_RST_BIT = 1;

endpackage

// File: rtl/drc_stretch.sv
module drc_stretch
    import drc_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 2
) (
    input  logic clk,
    input  logic async_req,
    input  logic sync_req,
    output logic rst_o
);

    localparam int unsigned CW = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STRETCH_CYC - 1);

    logic [1:0]      sync_q;
    stretch_state_t  state_q;
    logic [CW-1:0]   cnt_q;
    logic            still_req;

    // Two-flop release synchroniser; set immediately by the source.
    always_ff @(negedge clk or posedge async_req) begin
        if (async_req) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], 1'b0};
        end
    end

    assign still_req = sync_q[1] | sync_req;

    // State register: only the pulse sources themselves can reset it.
    always_ff @(negedge clk or posedge async_req) begin
        if (async_req) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (sync_req) begin
                        state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!still_req) begin
                        state_q <= ST_DRAIN;
                        cnt_q   <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (still_req) begin
                        state_q <= ST_HOLD;
                    end else if (cnt_q == CNT_LAST) begin
                        state_q <= ST_RUN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_HOLD;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        rst_o = (state_q != ST_RUN);
    end

endmodule

// File: rtl/drc_regs.sv
module drc_regs
    import drc_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned CFG_DEFAULT = 18
) (
    input  logic          clk,
    input  logic          reg_rst,
    input  logic          cnt_rst,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cfg_q,
    output logic          sw_rst_q,
    output logic          sw_pd_q
);

    localparam logic [DW-1:0] CFG_RST_VAL = DW'(CFG_DEFAULT);

    logic wr_cfg;
    logic wr_ctrl;

    assign wr_cfg  = wr_en && (wr_addr == ADDR_CFG);
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);

    // Register domain: configuration and the self-clearing reset request.
    always_ff @(posedge clk or posedge reg_rst) begin
        if (reg_rst) begin
            cfg_q    <= CFG_RST_VAL;
            sw_rst_q <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_q <= wr_data;
            end
            if (wr_ctrl) begin
                sw_rst_q <= wr_data[CTRL_RST_BIT];
            end
        end
    end

    // Counter domain: the analog power-down request.
    always_ff @(posedge clk or posedge cnt_rst) begin
        if (cnt_rst) begin
            sw_pd_q <= 1'b0;
        end else if (wr_ctrl) begin
            sw_pd_q <= wr_data[CTRL_PD_BIT];
        end
    end

endmodule

// File: rtl/dual_reset_ctrl.sv
module dual_reset_ctrl
    import drc_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned STRETCH_CYC = 2,
    parameter int unsigned CFG_DEFAULT = 18
) (
    input  logic          mclk,
    input  logic          por_i,
    input  logic          ext_rst_n,
    input  logic          hw_pd_n,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          cnt_rst_o,
    output logic          reg_rst_o,
    output logic          ana_pd_o,
    output logic          chip_pd_o,
    output logic [DW-1:0] cfg_q_o
);

    logic reg_src;
    logic cnt_src;
    logic sw_rst_q;
    logic sw_pd_q;

    assign reg_src = por_i | ~ext_rst_n;
    assign cnt_src = reg_src | ~hw_pd_n;

    drc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_cnt_dom (
        .clk       (mclk),
        .async_req (cnt_src),
        .sync_req  (sw_rst_q),
        .rst_o     (cnt_rst_o)
    );

    drc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_reg_dom (
        .clk       (mclk),
        .async_req (reg_src),
        .sync_req  (sw_rst_q),
        .rst_o     (reg_rst_o)
    );

    drc_regs #(.DW(DW), .CFG_DEFAULT(CFG_DEFAULT)) u_regs (
        .clk      (mclk),
        .reg_rst  (reg_rst_o),
        .cnt_rst  (cnt_rst_o),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_q    (cfg_q_o),
        .sw_rst_q (sw_rst_q),
        .sw_pd_q  (sw_pd_q)
    );

    assign chip_pd_o = ~hw_pd_n;
    assign ana_pd_o  = sw_pd_q | chip_pd_o;

endmodule

// File: rtl/dual_reset_ctrl_chk.sv
module dual_reset_ctrl_chk #(
    parameter int unsigned DW          = 8,
    parameter int unsigned CFG_DEFAULT = 18
) (
    input logic          mclk,
    input logic          por_i,
    input logic          ext_rst_n,
    input logic          hw_pd_n,
    input logic          cnt_rst_o,
    input logic          reg_rst_o,
    input logic          ana_pd_o,
    input logic [DW-1:0] cfg_q_o
);

    p_pd_pin_cnt_r1: assert property (@(negedge mclk) disable iff (por_i)
        !hw_pd_n |-> cnt_rst_o);

    p_ext_pin_both_r1: assert property (@(negedge mclk) disable iff (por_i)
        !ext_rst_n |-> (cnt_rst_o && reg_rst_o));

    p_reg_within_cnt_r2: assert property (@(posedge mclk) disable iff (por_i)
        reg_rst_o |-> cnt_rst_o);

    p_cnt_min_width_r3: assert property (@(negedge mclk) disable iff (por_i)
        $rose(cnt_rst_o) |=> cnt_rst_o);

    p_reg_min_width_r3: assert property (@(negedge mclk) disable iff (por_i)
        $rose(reg_rst_o) |=> reg_rst_o);

    p_reg_release_clean_r3: assert property (@(negedge mclk) disable iff (por_i)
        $fell(reg_rst_o) |-> ext_rst_n);

    p_swpd_cleared_r4: assert property (@(posedge mclk) disable iff (por_i)
        (cnt_rst_o && hw_pd_n) |-> !ana_pd_o);

    p_cfg_default_r7: assert property (@(posedge mclk) disable iff (por_i)
        reg_rst_o |-> (cfg_q_o == DW'(CFG_DEFAULT)));

endmodule

bind dual_reset_ctrl dual_reset_ctrl_chk #(.DW(DW), .CFG_DEFAULT(CFG_DEFAULT)) chk_i (
    .mclk      (mclk),
    .por_i     (por_i),
    .ext_rst_n (ext_rst_n),
    .hw_pd_n   (hw_pd_n),
    .cnt_rst_o (cnt_rst_o),
    .reg_rst_o (reg_rst_o),
    .ana_pd_o  (ana_pd_o),
    .cfg_q_o   (cfg_q_o)
);

// File: tb/dual_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_reset_ctrl_tb_top;

    localparam int unsigned DW   = 8;
    localparam int unsigned S    = 2;
    localparam int unsigned DEFV = 18;
    localparam int          SRC_EXT = 0;
    localparam int          SRC_PD  = 1;
    localparam int          SRC_SW  = 2;

    logic          mclk = 1'b0;
    logic          por_i;
    logic          ext_rst_n;
    logic          hw_pd_n;
    logic          wr_en;
    logic          wr_addr;
    logic [DW-1:0] wr_data;
    logic          cnt_rst_o;
    logic          reg_rst_o;
    logic          ana_pd_o;
    logic          chip_pd_o;
    logic [DW-1:0] cfg_q_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 mclk = ~mclk;

    dual_reset_ctrl #(.DW(DW), .STRETCH_CYC(S), .CFG_DEFAULT(DEFV)) dut_i (
        .mclk      (mclk),
        .por_i     (por_i),
        .ext_rst_n (ext_rst_n),
        .hw_pd_n   (hw_pd_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_rst_o (cnt_rst_o),
        .reg_rst_o (reg_rst_o),
        .ana_pd_o  (ana_pd_o),
        .chip_pd_o (chip_pd_o),
        .cfg_q_o   (cfg_q_o)
    );

    function automatic int exp_edges(input int src);
        return (src == SRC_SW) ? S + 2 : S + 3;
    endfunction

    function automatic logic exp_reg_pulse(input int src);
        return src != SRC_PD;
    endfunction

    function automatic logic [DW-1:0] exp_cfg(input int src, input logic [DW-1:0] prev);
        return (src == SRC_PD) ? prev : DW'(DEFV);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic step_neg();
        @(negedge mclk);
        #1;
    endtask

    task automatic do_write(input logic a, input logic [DW-1:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge mclk);
        #1;
        wr_en   = 1'b0;
    endtask

    // Walk the falling edges after a source ends and check both resets.
    task automatic check_release(input int src);
        for (int k = 1; k <= exp_edges(src); k++) begin
            step_neg();
            chk("R3", $sformatf("cnt_rst edge %0d", k), cnt_rst_o, (k < exp_edges(src)));
            chk("R2", $sformatf("reg_rst edge %0d", k), reg_rst_o,
                exp_reg_pulse(src) && (k < exp_edges(src)));
        end
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] prev_cfg;
        int unsigned   seed_dummy;
        seed_dummy = $urandom(32'd4242);
        por_i = 1'b0; ext_rst_n = 1'b1; hw_pd_n = 1'b1;
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        #1 por_i = 1'b1;
        #0.5;
        chk("R1", "por cnt_rst", cnt_rst_o, 1);
        chk("R2", "por reg_rst", reg_rst_o, 1);
        chk("R7", "por cfg default", cfg_q_o, DEFV);
        repeat (3) step_neg();
        @(posedge mclk); #1;
        por_i = 1'b0;
        check_release(SRC_EXT);

        // R5 / R6: software power-down set and clear
        step_neg();
        do_write(1'b1, 8'h01);
        chk("R5", "sw pd set", ana_pd_o, 1);
        chk("R6", "chip_pd idle", chip_pd_o, 0);
        chk("R1", "no reset on pd write", cnt_rst_o, 0);
        do_write(1'b1, 8'h00);
        chk("R5", "sw pd cleared by write", ana_pd_o, 0);

        // R4: external reset clears software power-down
        do_write(1'b1, 8'h01);
        ext_rst_n = 1'b0; #0.5;
        chk("R1", "ext cnt_rst async", cnt_rst_o, 1);
        chk("R4", "ext clears sw pd", ana_pd_o, 0);
        #0.5; step_neg();
        ext_rst_n = 1'b1;
        check_release(SRC_EXT);
        chk("R4", "sw pd stays clear", ana_pd_o, 0);

        // R4 / R6 / R7: hardware power-down keeps cfg, clears sw pd
        do_write(1'b0, 8'hA5);
        chk("R7", "cfg write", cfg_q_o, 8'hA5);
        do_write(1'b1, 8'h01);
        hw_pd_n = 1'b0; #0.5;
        chk("R6", "chip_pd on pin", chip_pd_o, 1);
        chk("R6", "ana_pd on pin", ana_pd_o, 1);
        chk("R2", "pd no reg_rst", reg_rst_o, 0);
        #0.5; step_neg(); step_neg();
        hw_pd_n = 1'b1;
        check_release(SRC_PD);
        chk("R4", "pd clears sw pd", ana_pd_o, 0);
        chk("R7", "cfg kept over pd", cfg_q_o, 8'hA5);

        // R3 / R8: software reset pulse, then silence
        step_neg();
        do_write(1'b1, 8'h02);
        chk("R3", "sw not before falling edge", cnt_rst_o, 0);
        check_release(SRC_SW);
        chk("R7", "cfg default after sw", cfg_q_o, DEFV);
        for (int k = 0; k < 6; k++) begin
            step_neg();
            chk("R8", "no second pulse", cnt_rst_o | reg_rst_o, 0);
        end

        // Same-cycle: software reset during hardware power-down
        do_write(1'b0, 8'h3C);
        hw_pd_n = 1'b0;
        step_neg();
        do_write(1'b1, 8'h02);
        for (int k = 1; k <= S + 2; k++) begin
            step_neg();
            chk("R3", $sformatf("sw under pd reg edge %0d", k), reg_rst_o, (k < S + 2));
            chk("R1", $sformatf("sw under pd cnt edge %0d", k), cnt_rst_o, 1);
        end
        chk("R7", "cfg default under pd", cfg_q_o, DEFV);
        hw_pd_n = 1'b1;
        check_release(SRC_PD);

        // Random rounds
        for (int it = 0; it < 40; it++) begin
            int src;
            int hold;
            logic pdb;
            src  = int'($urandom_range(2, 0));
            hold = int'($urandom_range(6, 1));
            pdb  = 1'($urandom_range(1, 0));
            prev_cfg = DW'($urandom_range(255, 0));
            step_neg();
            do_write(1'b0, prev_cfg);
            chk("R7", "rand cfg write", cfg_q_o, prev_cfg);
            do_write(1'b1, {6'b0, 1'b0, pdb});
            chk("R5", "rand sw pd", ana_pd_o, pdb);
            if (src == SRC_SW) begin
                do_write(1'b1, 8'h02);
            end else begin
                if (src == SRC_EXT) ext_rst_n = 1'b0;
                else                hw_pd_n   = 1'b0;
                #0.5;
                chk("R1", "rand pin cnt_rst", cnt_rst_o, 1);
                chk("R2", "rand pin reg_rst", reg_rst_o, exp_reg_pulse(src));
                chk("R6", "rand chip_pd", chip_pd_o, (src == SRC_PD));
                #0.5;
                repeat (hold) step_neg();
                ext_rst_n = 1'b1;
                hw_pd_n   = 1'b1;
            end
            check_release(src);
            chk("R7", "rand cfg after", cfg_q_o, exp_cfg(src, prev_cfg));
            chk("R4", "rand sw pd after", ana_pd_o, 0);
        end

        finish_run();
    end

endmodule